// File: doc/BRIEF.md
# Multi-Receiver Broadcast Channel Buffer

This block is a small buffered channel with one producer and a fixed number of consumers. Every message the producer writes is shown to all consumers. Each consumer has its own valid and dequeue pair, and all consumers share a data bus that carries the oldest stored message. The oldest entry stays at the head until every consumer has dequeued it. The producer's write is refused while all buffer slots are occupied.

Each consumer handles its port exactly as it would the read side of an ordinary FIFO. One bit per consumer records that the consumer has already taken the current head. After a consumer takes the head, its valid stays low until the head moves on. A consumer that does not dequeue therefore holds up every other consumer once the buffer fills.

The consumer count can be set to zero. The channel then accepts every write and keeps none of the data. The consumer count, the data width and the buffer depth are parameters. The depth defaults to two entries.

Top module: `bcast_channel`

## Requirements
- R1: Each accepted message reaches every consumer on `rxData`, unchanged. Each consumer receives the messages in the order they were accepted.
- R2: The head entry stays in place until all consumers have dequeued it. After consumer i takes the head, `rxValid[i]` is low until the head advances.
- R3: `sendReady` is low exactly when DEPTH entries are held. A write offered while `sendReady` is low is dropped and is never delivered.
- R4: `rxValid[i]` is high only while the head has not yet been taken by consumer i. Asserting `rxDeq[i]` while `rxValid[i]` is low has no effect.
- R5: In the cycle where the last outstanding consumer takes the head, a write is accepted at the same edge. The next head is then valid to all consumers in the following cycle.
- R6: With NUM_RX = 0, `sendReady` is always 1 and `rxValid` (one bit wide) is always 0.
- R7: Reset (`rstN` low) empties the buffer and clears all taken bits. After reset, `sendReady` is 1 and `rxValid` is all zeros.
- R8: Suppose one consumer does not dequeue. After DEPTH accepted writes, `sendReady` goes low, even if the other consumers have taken everything they can.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sendValid | input | 1 | Producer offers a message |
| sendData | input | DATA_W | Message from the producer |
| sendReady | output | 1 | High when a write will be accepted |
| rxValid | output | max(NUM_RX,1) | Per consumer: head pending for this consumer |
| rxData | output | DATA_W | Head message, shared by all consumers |
| rxDeq | input | max(NUM_RX,1) | Per consumer: take the head (effective only with rxValid) |

## Verification
The hardest case to reach is a consumer completing the head in the same cycle that a new write lands. The producer must be ready at that moment and the other consumers must already have taken the head. The stimulus gets there in three steps. It blocks one consumer and lets the others take a single stored message. It then releases the blocked consumer at the same falling edge where the driver offers the next word. A second hard state is a full buffer holding a refused write. That state comes from holding one consumer back while the driver keeps offering a marker value. The scoreboard then confirms that the marker never reaches any consumer.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
  // strobes from control to storage, one cycle each
  typedef struct packed {
    logic push;
    logic pop;
  } qStrobe_t;
endpackage

// File: rtl/bcast_ctrl.sv
module bcast_ctrl
  import bcast_pkg::*;
#(
  parameter int NUM_RX = 3,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sendValid,
  input  logic [NUM_RX-1:0] rxDeq,
  output logic              sendReady,
  output logic [NUM_RX-1:0] rxValid,
  output qStrobe_t          strobe
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  count;
  logic [NUM_RX-1:0] taken;
  logic [NUM_RX-1:0] takeNow;
  logic              notEmpty;
  logic              full;
  logic              headDone;

  assign notEmpty  = (count != '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign sendReady = !full;
  assign rxValid   = {NUM_RX{notEmpty}} & ~taken;
  assign takeNow   = rxDeq & rxValid;
  assign headDone  = notEmpty && (&(taken | takeNow));

  always_comb begin
    strobe.push = sendValid && !full;
    strobe.pop  = headDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) taken <= '0;
    else if (strobe.pop) taken <= '0;
    else taken <= taken | takeNow;
  end
endmodule

// File: rtl/bcast_store.sv
module bcast_store
  import bcast_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= stepPtr(wrPtr);
      if (strobe.pop)  rdPtr <= stepPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrData;
  end

  assign rdData = mem[rdPtr];
endmodule

// File: rtl/bcast_channel.sv
module bcast_channel
  import bcast_pkg::*;
#(
  parameter int NUM_RX = 3,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              sendValid,
  input  logic [DATA_W-1:0]                 sendData,
  output logic                              sendReady,
  output logic [(NUM_RX>0?NUM_RX:1)-1:0]    rxValid,
  output logic [DATA_W-1:0]                 rxData,
  input  logic [(NUM_RX>0?NUM_RX:1)-1:0]    rxDeq
);
  generate
    if (NUM_RX == 0) begin : gNoRx
      // nobody listens: accept and drop
      assign sendReady = 1'b1;
      assign rxValid   = '0;
      assign rxData    = '0;
    end else begin : gRx
      qStrobe_t strobe;

      bcast_ctrl #(.NUM_RX(NUM_RX), .DEPTH(DEPTH)) uCtrl (
        .clk(clk), .rstN(rstN), .sendValid(sendValid), .rxDeq(rxDeq),
        .sendReady(sendReady), .rxValid(rxValid), .strobe(strobe)
      );

      bcast_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uStore (
        .clk(clk), .rstN(rstN), .strobe(strobe),
        .wrData(sendData), .rdData(rxData)
      );
    end
  endgenerate
endmodule

// File: rtl/bcast_checker.sv
module bcast_checker #(
  parameter int NUM_RX = 3,
  parameter int DATA_W = 8
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           sendValid,
  input logic                           sendReady,
  input logic [(NUM_RX>0?NUM_RX:1)-1:0] rxValid,
  input logic [DATA_W-1:0]              rxData,
  input logic [(NUM_RX>0?NUM_RX:1)-1:0] rxDeq
);
  localparam int RX_W = (NUM_RX > 0) ? NUM_RX : 1;

  AST_RESET_EMPTY: assert property (@(posedge clk) !rstN |=> rxValid == '0); // R7

  AST_FULL_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sendReady) |-> $past(sendValid && sendReady)); // R3

  for (genvar i = 0; i < RX_W; i++) begin : gPer
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (rxValid[i] && !rxDeq[i]) |=> rxValid[i]); // R2

    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
      (rxValid[i] && !rxDeq[i]) |=> $stable(rxData)); // R1

    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rxValid[i]) |-> ($past(sendValid && sendReady) || $past(|(rxDeq & rxValid)))); // R4
  end
endmodule

bind bcast_channel bcast_checker #(.NUM_RX(NUM_RX), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .sendValid(sendValid), .sendReady(sendReady),
  .rxValid(rxValid), .rxData(rxData), .rxDeq(rxDeq)
);

// File: tb/tb_bcast_channel.sv
`timescale 1ns/1ps
module tb_bcast_channel;
  localparam int NRX = 3;
  localparam int DW  = 8;
  localparam int DEP = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sendValid = 1'b0;
  logic [DW-1:0] sendData = '0;
  logic sendReady;
  logic [NRX-1:0] rxValid;
  logic [DW-1:0] rxData;
  logic [NRX-1:0] rxDeq = '0;

  logic sendReadyN;
  logic [0:0] rxValidN;
  logic [DW-1:0] rxDataN;
  logic [0:0] rxDeqN = 1'b0;

  int nChecks = 0;
  int nFail = 0;

  logic [DW-1:0] expQ [NRX][$];
  logic [NRX-1:0] deqEn = '0;
  logic [NRX-1:0] forceDeq = '0;
  logic randMode = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #5 clk = ~clk;

  bcast_channel #(.NUM_RX(NRX), .DATA_W(DW), .DEPTH(DEP)) dut (
    .clk(clk), .rstN(rstN), .sendValid(sendValid), .sendData(sendData),
    .sendReady(sendReady), .rxValid(rxValid), .rxData(rxData), .rxDeq(rxDeq)
  );

  bcast_channel #(.NUM_RX(0), .DATA_W(DW), .DEPTH(DEP)) dutNone (
    .clk(clk), .rstN(rstN), .sendValid(sendValid), .sendData(sendData),
    .sendReady(sendReadyN), .rxValid(rxValidN), .rxData(rxDataN), .rxDeq(rxDeqN)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: offer one word, record it for every consumer when accepted
  task automatic sendWord(input logic [DW-1:0] d);
    @(negedge clk);
    sendValid = 1'b1;
    sendData = d;
    while (!sendReady) @(negedge clk);
    for (int i = 0; i < NRX; i++) expQ[i].push_back(d);
    @(posedge clk);
    #1 sendValid = 1'b0;
  endtask

  // monitor: choose dequeues, compare delivered data
  always @(negedge clk) begin
    logic [NRX-1:0] mask;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mask = randMode ? lfsr[NRX-1:0] : deqEn;
    for (int i = 0; i < NRX; i++) begin
      if (rxValid[i] && mask[i]) begin
        if (expQ[i].size() == 0) begin
          check(1'b0, "R1 unexpected delivery", rxData, 0);
        end else begin
          check(rxData == expQ[i][0], "R1 data", rxData, expQ[i][0]);
          void'(expQ[i].pop_front());
        end
      end
    end
    rxDeq = (mask & rxValid) | forceDeq;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(sendReady == 1'b1, "R7 ready after reset", sendReady, 1);
    check(rxValid == '0, "R7 valid after reset", rxValid, 0);
    check(rxValidN == 1'b0, "R6 valid none", rxValidN, 0);

    // R4: dequeue on empty is ignored
    forceDeq = '1;
    repeat (3) @(negedge clk);
    forceDeq = '0;
    deqEn = '0;
    sendWord(8'h5A);
    @(negedge clk);
    check(rxValid == 3'b111, "R4 deq while invalid ignored", rxValid, 3'b111);
    deqEn = '1;
    repeat (3) @(negedge clk);
    check(rxValid == '0, "R4 valid low once taken", rxValid, 0);

    // R8 / R2 / R3: consumer 2 held back
    deqEn = 3'b011;
    sendWord(8'h11);
    sendWord(8'h22);
    @(negedge clk);
    check(sendReady == 1'b0, "R8 stall fills buffer", sendReady, 0);
    check(rxValid == 3'b100, "R2 takers wait for head", rxValid, 3'b100);
    check(sendReadyN == 1'b1, "R6 ready none", sendReadyN, 1);
    sendValid = 1'b1;
    sendData = 8'hEE;
    repeat (4) @(negedge clk);
    check(sendReady == 1'b0, "R3 still full", sendReady, 0);
    sendValid = 1'b0;
    deqEn = 3'b111;
    repeat (8) @(negedge clk);
    check(rxValid == '0, "R3 refused write not delivered", rxValid, 0);
    check(expQ[2].size() == 0, "R1 consumer2 drained", expQ[2].size(), 0);

    // R5: last take coincides with a write
    deqEn = 3'b011;
    sendWord(8'h33);
    repeat (3) @(negedge clk);
    check(rxValid == 3'b100, "R5 setup", rxValid, 3'b100);
    @(posedge clk);
    deqEn = 3'b111;
    sendWord(8'h44);
    @(negedge clk);
    check(rxValid == 3'b111, "R5 new head valid to all", rxValid, 3'b111);
    repeat (4) @(negedge clk);

    // R1: irregular consumer pattern
    randMode = 1'b1;
    for (int k = 0; k < 30; k++) sendWord(8'(k * 7 + 3));
    randMode = 1'b0;
    deqEn = '1;
    repeat (20) @(negedge clk);
    for (int i = 0; i < NRX; i++)
      check(expQ[i].size() == 0, "R1 all delivered", expQ[i].size(), 0);
    check(rxValid == '0, "R1 empty at end", rxValid, 0);
    check(sendReady == 1'b1, "R3 ready when empty", sendReady, 1);
    check(rxValidN == 1'b0, "R6 none never valid", rxValidN, 0);

    // R7: reset mid-traffic
    deqEn = '0;
    sendWord(8'h77);
    #1 rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NRX; i++) expQ[i].delete();
    @(negedge clk);
    check(rxValid == '0, "R7 reset empties", rxValid, 0);
    check(sendReady == 1'b1, "R7 reset ready", sendReady, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule